// File: doc/BRIEF.md
# DMA Address and Count Registers

This block holds the processor-visible setup registers of a simple DMA engine. A count register carries a 14-bit word count together with a transfer direction flag and an enable flag. An address register carries a 22-bit byte address of a 16-bit word.

Software loads the address in two halves. The new address bits come from the address lines of the write cycle, not from the data bus. Address bit 14 of the write selects which half is loaded. When software writes the count, the stored value is one more than the value written.

A transfer engine outside this block pulses a step strobe once per word moved. Each pulse moves the count down by one and the address up by one word. The block drives the current address, count, direction and enable to that engine at all times. Register reads return their data one cycle after the read strobe.

Top module: `dma_ctl_regs`

## Requirements
- R1: While reset is active and in the cycle after it is released, `dma_count`, `dma_dir`, `dma_en`, `dma_addr` and `rd_data` are all zero.
- R2: A write with `reg_sel`=0 (count register) loads `dma_dir` from data bit 14 and `dma_en` from data bit 15. It loads `dma_count` with data bits 13:0 plus one, modulo 2^14, so 0x3FFF becomes 0. The new values appear on the outputs after the write's clock edge.
- R3: A read with `reg_sel`=0 puts the count held in the read cycle on `rd_data[13:0]` after the next clock edge, with `rd_data[15:14]` = 2'b11.
- R4: A write with `reg_sel`=1 (address register) and `bus_addr[14]`=1 loads `dma_addr[21:9]` from `bus_addr[13:1]` and leaves `dma_addr[8:0]` unchanged.
- R5: A write with `reg_sel`=1 and `bus_addr[14]`=0 loads `dma_addr[8:1]` from `bus_addr[8:1]` and leaves `dma_addr[21:9]` unchanged. `bus_addr[15]`, `bus_addr[13:9]` and `bus_addr[0]` have no effect.
- R6: `dma_addr[0]` is always 0.
- R7: A read with `reg_sel`=1 returns 0xFFFF on `rd_data` after the next clock edge.
- R8: Each cycle with `xfer_step`=1 lowers `dma_count` by one, wrapping from 0 to 0x3FFF. In the same cycle it raises `dma_addr` by 2, wrapping from 0x3FFFFE to 0.
- R9: A register write takes precedence over `xfer_step` for the register it writes, in the same cycle. The other register still steps.
- R10: `rd_data` holds its value in every cycle without `rd_en`, whatever writes or steps take place.

Register select encoding: `reg_sel`=0 selects the count register and `reg_sel`=1 selects the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = count register, 1 = address register |
| bus_addr | input | 16 | Low address lines of the bus cycle |
| wr_data | input | 16 | Write data |
| xfer_step | input | 1 | One pulse per transferred word |
| dma_addr | output | 22 | Current DMA byte address |
| dma_count | output | 14 | Current word count |
| dma_dir | output | 1 | Transfer direction flag |
| dma_en | output | 1 | DMA enable flag |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The bench writes count values 0x3FFF and 0. A design that left out the +1 on load, or that saturated instead of wrapping, would show the wrong count both after the load and after the next step.

It loads each address half with patterns whose other bits are set, and with `bus_addr[0]` set. A design that took the address from the data bus, decoded the wrong half select, or let bit 0 through would corrupt the half that should have been kept.

It drives writes and steps in the same cycle and steps the address across its top. A design with the wrong priority or a carry cut at the half boundary would show a wrong address there. It also checks that `rd_data` holds its value across writes.

// File: rtl/dma_regs_pkg.sv
// Shared definitions for the DMA setup registers.
// Assumes a one-bit register select decoded by the bus fabric outside.
package dma_regs_pkg;

    // Which register a bus access targets.
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_ADDR  = 1'b1
    } dma_reg_sel_e;

endpackage

// File: rtl/dma_count_reg.sv
// Word count with direction and enable flags.
// A load takes the count from the low data bits and adds one. The next two
// data bits above the count are the direction and enable flags. A step
// lowers the count by one. A load beats a step in the same cycle.
// Assumes BUS_W >= CNT_W + 2.
module dma_count_reg #(
    parameter int CNT_W = 14,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic             en
);
    localparam int DIR_BIT = CNT_W;
    localparam int EN_BIT  = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             en_q;

    // Count register: reset, load plus one, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= wr_data[CNT_W-1:0] + CNT_W'(1);
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Flag registers: change only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            en_q  <= 1'b0;
        end else if (load) begin
            dir_q <= wr_data[DIR_BIT];
            en_q  <= wr_data[EN_BIT];
        end
    end

    assign count = cnt_q;
    assign dir   = dir_q;
    assign en    = en_q;

    AST_CNT_LOAD_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CNT_W'($past(wr_data[CNT_W-1:0]) + CNT_W'(1)))); // R2
    AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(dir_q) && $stable(en_q))); // R2
endmodule

// File: rtl/dma_addr_reg.sv
// Word-aligned DMA address loaded in two halves from the bus address lines.
// One bus address bit selects the half. The high half takes bus bits from
// bit 1 upward. The low half takes the matching bus bits. Only the word
// address is stored, so byte bit 0 is always zero. A step moves one word.
// A load beats a step. Assumes ADDR_W - SPLIT < HALF_BIT < BUS_W.
module dma_addr_reg #(
    parameter int ADDR_W   = 22,
    parameter int SPLIT    = 9,
    parameter int BUS_W    = 16,
    parameter int HALF_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int WORD_W = ADDR_W - 1;
    localparam int HI_W   = ADDR_W - SPLIT;
    localparam int LO_W   = SPLIT - 1;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    // Next word address from a half load or a step.
    always_comb begin
        word_d = word_q;
        if (load) begin
            if (bus_addr[HALF_BIT]) begin
                word_d = {bus_addr[HI_W:1], word_q[LO_W-1:0]};
            end else begin
                word_d = {word_q[WORD_W-1:LO_W], bus_addr[LO_W:1]};
            end
        end else if (step) begin
            word_d = word_q + WORD_W'(1);
        end
    end

    // Word address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign addr = {word_q, 1'b0};

    AST_ADDR_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bus_addr[HALF_BIT]) |=> (addr[SPLIT-1:0] == $past(addr[SPLIT-1:0]))); // R4
    AST_ADDR_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bus_addr[HALF_BIT]) |=> (addr[ADDR_W-1:SPLIT] == $past(addr[ADDR_W-1:SPLIT]))); // R5
    AST_ADDR_STEP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(2)))); // R8
    AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr)); // R9
endmodule

// File: rtl/dma_rd_mux.sv
// Registered readback. A count read returns the count with all upper bits
// set. An address read returns all ones, since the address is write-only.
// Without a read strobe the output holds.
module dma_rd_mux #(
    parameter int CNT_W = 14,
    parameter int BUS_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  dma_regs_pkg::dma_reg_sel_e sel,
    input  logic [CNT_W-1:0]           count,
    output logic [BUS_W-1:0]           rd_data
);
    import dma_regs_pkg::*;

    localparam int PAD_W = BUS_W - CNT_W;

    logic [BUS_W-1:0] rd_q;

    // Capture the selected register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            if (sel == SEL_ADDR) begin
                rd_q <= '1;
            end else begin
                rd_q <= {{PAD_W{1'b1}}, count};
            end
        end
    end

    assign rd_data = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_RD_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_ADDR) |=> (rd_data == {BUS_W{1'b1}})); // R7
    AST_RD_CNT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_COUNT) |=> (rd_data[CNT_W-1:0] == $past(count))); // R3
endmodule

// File: rtl/dma_ctl_regs.sv
// Top level of the DMA setup registers. It decodes write strobes to the
// count and address registers, forwards the step strobe to both, and
// registers readback. Transfer sequencing and arbitration live outside.
module dma_ctl_regs #(
    parameter int CNT_W    = 14,
    parameter int ADDR_W   = 22,
    parameter int BUS_W    = 16,
    parameter int SPLIT    = 9,
    parameter int HALF_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              xfer_step,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [CNT_W-1:0]  dma_count,
    output logic              dma_dir,
    output logic              dma_en,
    output logic [BUS_W-1:0]  rd_data
);
    import dma_regs_pkg::*;

    dma_reg_sel_e sel;
    logic         cnt_load;
    logic         adr_load;

    // Decode the write strobe to one register.
    always_comb begin
        sel      = dma_reg_sel_e'(reg_sel);
        cnt_load = wr_en && (sel == SEL_COUNT);
        adr_load = wr_en && (sel == SEL_ADDR);
    end

    dma_count_reg #(.CNT_W(CNT_W), .BUS_W(BUS_W)) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .wr_data (wr_data),
        .step    (xfer_step),
        .count   (dma_count),
        .dir     (dma_dir),
        .en      (dma_en)
    );

    dma_addr_reg #(.ADDR_W(ADDR_W), .SPLIT(SPLIT), .BUS_W(BUS_W), .HALF_BIT(HALF_BIT)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adr_load),
        .bus_addr (bus_addr),
        .step     (xfer_step),
        .addr     (dma_addr)
    );

    dma_rd_mux #(.CNT_W(CNT_W), .BUS_W(BUS_W)) rd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .count   (dma_count),
        .rd_data (rd_data)
    );

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        adr_load |=> (dma_addr[0] == 1'b0)); // R6
    AST_CNT_READ_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !reg_sel) |=> (rd_data[BUS_W-1:CNT_W] == '1)); // R3
    AST_WRITE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_load && xfer_step) |=> (dma_count == CNT_W'($past(wr_data[CNT_W-1:0]) + CNT_W'(1)))); // R9
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
// Directed bench for the DMA setup registers. Inputs are driven at the
// falling edge and outputs checked one time unit after the rising edge.
module dma_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] wr_data = '0;
    logic        xfer_step = 1'b0;
    logic [21:0] dma_addr;
    logic [13:0] dma_count;
    logic        dma_dir;
    logic        dma_en;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Expected state, built from the requirements.
    logic [21:0] e_addr = '0;
    logic [13:0] e_cnt = '0;
    logic        e_dir = 1'b0;
    logic        e_en = 1'b0;
    logic [15:0] e_rd = '0;

    always #4 clk = ~clk;

    dma_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .bus_addr(bus_addr), .wr_data(wr_data), .xfer_step(xfer_step),
        .dma_addr(dma_addr), .dma_count(dma_count), .dma_dir(dma_dir),
        .dma_en(dma_en), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle; updates the expected state per R2, R4, R5, R7, R8, R9.
    task automatic cyc(input logic wr, input logic rd, input logic sel,
                       input logic [15:0] ba, input logic [15:0] d, input logic st);
        @(negedge clk);
        wr_en = wr; rd_en = rd; reg_sel = sel; bus_addr = ba; wr_data = d; xfer_step = st;
        if (rd) e_rd = sel ? 16'hFFFF : {2'b11, e_cnt};
        if (wr && !sel) begin
            e_cnt = d[13:0] + 14'd1; e_dir = d[14]; e_en = d[15];
        end else if (st) begin
            e_cnt = e_cnt - 14'd1;
        end
        if (wr && sel) begin
            if (ba[14]) e_addr = {ba[13:1], e_addr[8:0]};
            else        e_addr = {e_addr[21:9], ba[8:1], 1'b0};
        end else if (st) begin
            e_addr = e_addr + 22'd2;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; xfer_step = 1'b0;
    endtask

    task automatic chk_all(input string req);
        chk(req, "count", 32'(dma_count), 32'(e_cnt));
        chk(req, "dir", 32'(dma_dir), 32'(e_dir));
        chk(req, "en", 32'(dma_en), 32'(e_en));
        chk(req, "addr", 32'(dma_addr), 32'(e_addr));
        chk(req, "rd_data", 32'(rd_data), 32'(e_rd));
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk_all("R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk_all("R1");
    endtask

    task automatic t_count_write();
        cyc(1, 0, 0, 16'h0000, 16'h8123, 0);
        chk("R2", "count", 32'(dma_count), 32'h124);
        chk("R2", "en", 32'(dma_en), 1);
        chk("R2", "dir", 32'(dma_dir), 0);
        cyc(1, 0, 0, 16'h0000, 16'h7FFF, 0);
        chk("R2", "count wrap", 32'(dma_count), 32'h0);
        chk_all("R2");
    endtask

    task automatic t_count_read();
        cyc(0, 1, 0, 16'h0000, 16'h0000, 0);
        chk("R3", "rd zero count", 32'(rd_data), 32'hC000);
        cyc(1, 0, 0, 16'h0000, 16'h0005, 0);
        cyc(0, 1, 0, 16'h0000, 16'h0000, 0);
        chk("R3", "rd count", 32'(rd_data), 32'hC006);
    endtask

    task automatic t_addr_halves();
        cyc(1, 0, 1, 16'h6ABC, 16'h1234, 0);
        chk("R4", "hi load", 32'(dma_addr), 32'h2ABC00);
        cyc(1, 0, 1, 16'h00FF, 16'hFFFF, 0);
        chk("R5", "lo load", 32'(dma_addr), 32'h2ABCFE);
        chk("R6", "bit0", 32'(dma_addr[0]), 0);
        cyc(1, 0, 1, 16'h4002, 16'h0000, 0);
        chk("R4", "hi keeps lo", 32'(dma_addr), 32'h0002FE);
        cyc(1, 0, 1, 16'hBE11, 16'h0000, 0);
        chk("R5", "lo ignores upper bits", 32'(dma_addr), 32'h000210);
        chk_all("R5");
    endtask

    task automatic t_addr_read();
        cyc(0, 1, 1, 16'h0000, 16'h0000, 0);
        chk("R7", "addr read", 32'(rd_data), 32'hFFFF);
    endtask

    task automatic t_step();
        cyc(1, 0, 0, 16'h0000, 16'h0009, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 16'h0000, 16'h0000, 1);
        chk("R8", "count after steps", 32'(dma_count), 32'h7);
        chk("R8", "addr after steps", 32'(dma_addr), 32'h000216);
        cyc(1, 0, 0, 16'h0000, 16'h3FFF, 0);
        cyc(1, 0, 1, 16'h7FFE, 16'h0000, 0);
        cyc(1, 0, 1, 16'h01FE, 16'h0000, 0);
        chk("R8", "addr top", 32'(dma_addr), 32'h3FFFFE);
        cyc(0, 0, 0, 16'h0000, 16'h0000, 1);
        chk("R8", "count wrap", 32'(dma_count), 32'h3FFF);
        chk("R8", "addr wrap", 32'(dma_addr), 32'h0);
        cyc(1, 0, 1, 16'h01FE, 16'h0000, 0);
        cyc(0, 0, 0, 16'h0000, 16'h0000, 1);
        chk("R8", "carry into high half", 32'(dma_addr), 32'h000200);
    endtask

    task automatic t_priority();
        cyc(1, 0, 0, 16'h0000, 16'h4010, 1);
        chk("R9", "count write wins", 32'(dma_count), 32'h11);
        chk("R9", "addr still steps", 32'(dma_addr), 32'h000202);
        cyc(1, 0, 1, 16'h0040, 16'h0000, 1);
        chk("R9", "addr write wins", 32'(dma_addr), 32'h000240);
        chk("R9", "count still steps", 32'(dma_count), 32'h10);
        chk_all("R9");
    endtask

    task automatic t_hold();
        cyc(0, 1, 0, 16'h0000, 16'h0000, 0);
        chk("R10", "read value", 32'(rd_data), 32'hC010);
        cyc(1, 0, 0, 16'h0000, 16'h0100, 0);
        cyc(1, 0, 1, 16'h7FFE, 16'h0000, 1);
        cyc(0, 0, 0, 16'h0000, 16'h0000, 1);
        chk("R10", "rd_data held", 32'(rd_data), 32'hC010);
        chk_all("R10");
    endtask

    initial begin
        t_reset();
        t_count_write();
        t_count_read();
        t_addr_halves();
        t_addr_read();
        t_step();
        t_priority();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule